// File: doc/BRIEF.md
# Interrupt-Capable Eight-Line GPIO Port

This block is an eight-line general-purpose I/O port behind a simple register interface. Writes are single-cycle: `bus_we` with an address and a byte. Reads are combinational from `bus_addr`. A direction byte chooses, line by line, whether the pad is driven from the output-data byte or is sampled as an input. Every incoming pin passes through a two-flop synchronizer. A line can also pass through a debounce filter of its own, which is clocked by a slow sample strobe `db_tick`.

Each line can raise an interrupt. It runs in level mode or edge mode, and a polarity bit picks low/falling or high/rising. An enable bit gates each line. Edge events are held in a per-line latch. Software clears a latch by writing a one to its bit of an acknowledge register. Because there is no both-edges mode, software follows both edges by flipping the polarity bit after each event. The detector therefore reacts only to input transitions and never to a change of configuration.

Per line, the debounce filter is a two-state machine. In DB_STEADY, a mismatch between input and output takes the *start* transition to DB_SETTLE, with the tick counter cleared. In DB_SETTLE, an input that matches the output again takes the *bounce* transition back to DB_STEADY. The fourth strobe with the input still differing takes the *accept* transition: the output is updated and the filter returns to DB_STEADY. The edge latch is also a two-state machine. EV_CLEAR takes *capture* to EV_LATCHED on a qualifying transition. EV_LATCHED takes *release* back to EV_CLEAR on an acknowledge, on disable or on leaving edge mode, unless a new event arrives in that same cycle.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads 0. `pin_oe`, `irq_line` and `irq_any` are 0.
- R2: Bit n of the direction register (offset 0x10) set to 1 drives `pin_oe[n]` high and `pin_out[n]` from the output-data byte. Reading offset 0x00 returns the stored data bit for output lines and the synchronized pin for input lines.
- R3: With the edge-select bit (offset 0x90) at 1, an enabled line latches an event on a rising input when its polarity bit (offset 0x94) is 1 and on a falling input when it is 0. Without debounce the event appears on `irq_line` after the third rising clock edge that follows the pin change, and not after the second.
- R4: With the edge-select bit at 0, an enabled line's status follows its qualified input live: high when the input equals the polarity bit, with no latching.
- R5: Writing a 1 to bit n of the acknowledge register (offset 0x98) clears line n's latched event. Bits written 0 leave their latches unchanged. Acknowledge has no effect on level-mode lines. Offset 0x98 reads as 0.
- R6: A line whose enable bit (offset 0x9C) is 0 never shows an interrupt. Edges that occur while it is disabled are not latched, so enabling it later shows nothing.
- R7: Changing the polarity bit of an enabled edge-mode line while its input is steady creates no event.
- R8: With debounce enabled (offset 0xA8), a new input value reaches the detector only after it has differed from the filtered value across 4 consecutive `db_tick` strobes. A pulse shorter than that is discarded.
- R9: `irq_line` equals the status register at offset 0xA0, which is each line's status ANDed with its enable. `irq_any` is the OR of `irq_line`.
- R10: When an acknowledge write to a line falls in the same clock edge as a new qualifying edge on that line, the new event stays latched.
- R11: Offsets 0x10, 0x90, 0x94, 0x9C and 0xA8 read back what was last written. Any unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 8 | Write data, one bit per line |
| bus_rdata | output | 8 | Combinational read data |
| db_tick | input | 1 | Debounce sample strobe |
| pin_in | input | 8 | Raw pad inputs |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| irq_any | output | 1 | Combined interrupt |
| irq_line | output | 8 | Per-line interrupts |

## Verification
An acknowledge write and a new edge capture can land on the same line in the same clock edge. Which one wins decides whether an event is lost. The bench provokes this by raising a pin and timing the acknowledge write so that it commits on exactly the third edge after the pin change, which is the edge where the capture happens. It then requires the line to remain pending. A second overlap, a polarity write while an edge-mode line sits at a steady level, is driven in both directions and must leave the status at zero.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int REG_AW = 8;

    localparam logic [REG_AW-1:0] OFF_DATA      = 8'h00;
    localparam logic [REG_AW-1:0] OFF_DIR       = 8'h10;
    localparam logic [REG_AW-1:0] OFF_TRIG_EDGE = 8'h90;
    localparam logic [REG_AW-1:0] OFF_TRIG_POL  = 8'h94;
    localparam logic [REG_AW-1:0] OFF_ACK       = 8'h98;
    localparam logic [REG_AW-1:0] OFF_IRQ_EN    = 8'h9C;
    localparam logic [REG_AW-1:0] OFF_STATUS    = 8'hA0;
    localparam logic [REG_AW-1:0] OFF_FILT_EN   = 8'hA8;

    typedef enum logic {
        DB_STEADY = 1'b0,
        DB_SETTLE = 1'b1
    } db_state_t;

    typedef enum logic {
        EV_CLEAR   = 1'b0,
        EV_LATCHED = 1'b1
    } ev_state_t;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce
    import gpio_irq_pkg::*;
#(
    parameter int DB_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic din_i,
    output logic dout_o
);
    localparam int CW = (DB_TICKS > 1) ? $clog2(DB_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(DB_TICKS - 1);

    db_state_t     st_q, st_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          out_n;

    // next-state decision
    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        out_n = dout_o;
        unique case (st_q)
            DB_STEADY: begin
                if (din_i != dout_o) begin       // start
                    st_n  = DB_SETTLE;
                    cnt_n = '0;
                end
            end
            DB_SETTLE: begin
                if (din_i == dout_o) begin       // bounce
                    st_n = DB_STEADY;
                end else if (tick_i) begin
                    if (cnt_q == LAST) begin     // accept
                        out_n = din_i;
                        st_n  = DB_STEADY;
                    end else begin
                        cnt_n = cnt_q + CW'(1);
                    end
                end
            end
            default: st_n = DB_STEADY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= DB_STEADY;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dout_o <= 1'b0;
        else        dout_o <= out_n;
    end

    // R8: the filtered value only moves on a sample strobe
    p_hold_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(dout_o));

    // R8: an input that already matches never moves the output
    p_hold_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (din_i == dout_o) |=> $stable(dout_o));
endmodule

// File: rtl/gpio_line_detect.sv
module gpio_line_detect
    import gpio_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    input  logic edge_mode_i,
    input  logic pol_i,
    input  logic en_i,
    input  logic ack_i,
    output logic stat_o
);
    ev_state_t st_q, st_n;
    logic      lvl_prev_q;
    logic      hit;

    assign hit = en_i && edge_mode_i &&
                 (pol_i ? (lvl_i && !lvl_prev_q) : (!lvl_i && lvl_prev_q));

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            EV_CLEAR:   if (hit) st_n = EV_LATCHED;                       // capture
            EV_LATCHED: if (!hit && (ack_i || !en_i || !edge_mode_i))
                            st_n = EV_CLEAR;                              // release
            default:    st_n = EV_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= EV_CLEAR;
            lvl_prev_q <= 1'b0;
        end else begin
            st_q       <= st_n;
            lvl_prev_q <= lvl_i;
        end
    end

    // output process
    always_comb begin
        if (!en_i)            stat_o = 1'b0;
        else if (edge_mode_i) stat_o = (st_q == EV_LATCHED);
        else                  stat_o = (lvl_i == pol_i);
    end

    // R6: nothing is captured while disabled
    p_no_capture_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (st_q == EV_CLEAR));

    // R7: a steady input never creates an event, whatever the polarity does
    p_steady_no_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == EV_CLEAR && lvl_i == lvl_prev_q) |=> (st_q == EV_CLEAR));

    // R5: acknowledge without a new transition leaves the latch clear
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && lvl_i == lvl_prev_q) |=> (st_q == EV_CLEAR));

    // R10: a rising capture survives a same-edge acknowledge
    p_capture_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && edge_mode_i && pol_i && lvl_i && !lvl_prev_q) |=> (st_q == EV_LATCHED));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NLINES   = 8,
    parameter int DB_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [NLINES-1:0] bus_wdata,
    output logic [NLINES-1:0] bus_rdata,
    input  logic              db_tick,
    input  logic [NLINES-1:0] pin_in,
    output logic [NLINES-1:0] pin_out,
    output logic [NLINES-1:0] pin_oe,
    output logic              irq_any,
    output logic [NLINES-1:0] irq_line
);
    logic [NLINES-1:0] out_q, dir_q, trig_edge_q, trig_pol_q, irq_en_q, filt_en_q;
    logic [NLINES-1:0] pin_s, filt_v, qual_v, ack_v, stat_v;

    // register file
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q       <= '0;
            dir_q       <= '0;
            trig_edge_q <= '0;
            trig_pol_q  <= '0;
            irq_en_q    <= '0;
            filt_en_q   <= '0;
        end else if (bus_we) begin
            case (bus_addr)
                OFF_DATA:      out_q       <= bus_wdata;
                OFF_DIR:       dir_q       <= bus_wdata;
                OFF_TRIG_EDGE: trig_edge_q <= bus_wdata;
                OFF_TRIG_POL:  trig_pol_q  <= bus_wdata;
                OFF_IRQ_EN:    irq_en_q    <= bus_wdata;
                OFF_FILT_EN:   filt_en_q   <= bus_wdata;
                default: ;
            endcase
        end
    end

    assign ack_v = (bus_we && bus_addr == OFF_ACK) ? bus_wdata : '0;

    gpio_sync2 #(.W(NLINES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_s)
    );

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        gpio_debounce #(.DB_TICKS(DB_TICKS)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_i (db_tick),
            .din_i  (pin_s[g]),
            .dout_o (filt_v[g])
        );

        assign qual_v[g] = filt_en_q[g] ? filt_v[g] : pin_s[g];

        gpio_line_detect u_det (
            .clk         (clk),
            .rst_n       (rst_n),
            .lvl_i       (qual_v[g]),
            .edge_mode_i (trig_edge_q[g]),
            .pol_i       (trig_pol_q[g]),
            .en_i        (irq_en_q[g]),
            .ack_i       (ack_v[g]),
            .stat_o      (stat_v[g])
        );
    end

    // read mux
    always_comb begin
        case (bus_addr)
            OFF_DATA:      bus_rdata = (out_q & dir_q) | (pin_s & ~dir_q);
            OFF_DIR:       bus_rdata = dir_q;
            OFF_TRIG_EDGE: bus_rdata = trig_edge_q;
            OFF_TRIG_POL:  bus_rdata = trig_pol_q;
            OFF_IRQ_EN:    bus_rdata = irq_en_q;
            OFF_STATUS:    bus_rdata = stat_v;
            OFF_FILT_EN:   bus_rdata = filt_en_q;
            default:       bus_rdata = '0;
        endcase
    end

    assign pin_out  = out_q;
    assign pin_oe   = dir_q;
    assign irq_line = stat_v;
    assign irq_any  = |stat_v;
endmodule

// File: tb/sim_gpio_irq_port.sv
`timescale 1ns/1ps
module sim_gpio_irq_port;
    localparam real HALF = 2.5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       db_tick = 1'b0;
    logic [7:0] pins = 8'h00;
    logic [7:0] pin_out, pin_oe, irq_line;
    logic       irq_any;

    int checks = 0;
    int errors = 0;
    logic [7:0] sh_dir = 8'h00;

    gpio_irq_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .db_tick(db_tick),
        .pin_in(pins), .pin_out(pin_out), .pin_oe(pin_oe),
        .irq_any(irq_any), .irq_line(irq_line)
    );

    initial forever #(HALF) clk = ~clk;

    // sample strobe: one cycle in eight
    initial begin
        int n = 0;
        forever begin
            @(negedge clk);
            n = n + 1;
            db_tick = (n % 8 == 0);
        end
    end

    initial begin
        #(5.0 * 150000);
        checks++; errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        if (a == 8'h10) sh_dir = d;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic clear_cfg();
        wr(8'h9C, 8'h00); wr(8'h90, 8'h00); wr(8'h94, 8'h00);
        wr(8'hA8, 8'h00); wr(8'h10, 8'h00); wr(8'h98, 8'hFF);
    endtask

    function automatic logic [7:0] exp_level(input logic [7:0] p, input logic [7:0] pol,
                                             input logic [7:0] en);
        return en & ~(p ^ pol);
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a, input logic [7:0] val,
                                            input logic [7:0] dir, input logic [7:0] p);
        return (a == 8'h00) ? ((val & dir) | (p & ~dir)) : val;
    endfunction

    initial begin
        logic [7:0] v;
        logic [7:0] offs [6] = '{8'h00, 8'h10, 8'h90, 8'h94, 8'h9C, 8'hA8};
        void'($urandom(32'h1234_5EED));

        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk(pin_oe, 8'h00, "R1 pin_oe");
        chk(irq_line, 8'h00, "R1 irq_line");
        chk({7'h0, irq_any}, 8'h00, "R1 irq_any");
        rd(8'h10, v); chk(v, 8'h00, "R1 dir");
        rd(8'h9C, v); chk(v, 8'h00, "R1 enable");

        // R2 direction and data read
        wr(8'h10, 8'hF0); wr(8'h00, 8'hA5);
        pins = 8'h3C; step(3);
        chk(pin_oe, 8'hF0, "R2 pin_oe");
        chk(pin_out, 8'hA5, "R2 pin_out");
        rd(8'h00, v); chk(v, 8'hAC, "R2 data read mix");

        // R11 random readback
        for (int i = 0; i < 12; i++) begin
            int k = $urandom % 6;
            logic [7:0] d = 8'($urandom);
            wr(offs[k], d);
            rd(offs[k], v);
            chk(v, exp_read(offs[k], d, sh_dir, pins), "R11 readback");
        end
        rd(8'h98, v); chk(v, 8'h00, "R11 ack reads 0");
        rd(8'h04, v); chk(v, 8'h00, "R11 unmapped");

        clear_cfg();
        pins = 8'h00; step(4);
        wr(8'h98, 8'hFF);

        // R3 rising on line 0, falling on line 1; R5 selective ack
        wr(8'h90, 8'h03); wr(8'h94, 8'h01); wr(8'h9C, 8'h03);
        pins = 8'h03; step(2);
        chk(irq_line, 8'h00, "R3 not yet after two edges");
        step(1);
        chk(irq_line, 8'h01, "R3 rising captured");
        pins = 8'h01; step(3);
        chk(irq_line, 8'h03, "R3 falling captured");
        rd(8'hA0, v); chk(v, irq_line, "R9 status reg");
        chk({7'h0, irq_any}, 8'h01, "R9 irq_any");
        wr(8'h98, 8'h01);
        chk(irq_line, 8'h02, "R5 ack bit0 only");
        wr(8'h98, 8'h02);
        chk(irq_line, 8'h00, "R5 ack bit1");
        chk({7'h0, irq_any}, 8'h00, "R9 irq_any low");

        // R7 polarity flip at steady level on line 2
        clear_cfg();
        pins = 8'h04; step(4);
        wr(8'h90, 8'h04); wr(8'h94, 8'h04); wr(8'h9C, 8'h04);
        step(2); chk(irq_line, 8'h00, "R7 steady high");
        wr(8'h94, 8'h00); step(2); chk(irq_line, 8'h00, "R7 flip to falling");
        wr(8'h94, 8'h04); step(2); chk(irq_line, 8'h00, "R7 flip to rising");
        pins = 8'h00; step(3); chk(irq_line, 8'h00, "R3 falling ignored in rising mode");
        pins = 8'h04; step(3); chk(irq_line, 8'h04, "R3 rising after flips");

        // R6 disabled line 4
        clear_cfg();
        pins = 8'h00; step(4);
        wr(8'h90, 8'h10); wr(8'h94, 8'h10);
        pins = 8'h10; step(3);
        chk(irq_line, 8'h00, "R6 edge while disabled");
        wr(8'h9C, 8'h10); step(1);
        chk(irq_line, 8'h00, "R6 not latched on enable");
        wr(8'h9C, 8'h00); wr(8'h90, 8'h00);
        step(2); chk(irq_line, 8'h00, "R6 level match but disabled");

        // R10 ack and capture on the same edge, line 5
        clear_cfg();
        pins = 8'h00; step(4);
        wr(8'h90, 8'h20); wr(8'h94, 8'h20); wr(8'h9C, 8'h20);
        pins = 8'h20;
        step(2);
        bus_we = 1'b1; bus_addr = 8'h98; bus_wdata = 8'h20;
        step(1);
        bus_we = 1'b0;
        chk(irq_line, 8'h20, "R10 capture beats ack");
        wr(8'h98, 8'h20);
        chk(irq_line, 8'h00, "R5 later ack clears");

        // R4 random level mode
        clear_cfg();
        for (int i = 0; i < 16; i++) begin
            logic [7:0] pol = 8'($urandom);
            logic [7:0] en  = 8'($urandom);
            wr(8'h94, pol); wr(8'h9C, en);
            pins = 8'($urandom);
            step(3);
            chk(irq_line, exp_level(pins, pol, en), "R4 level status");
            chk({7'h0, irq_any}, {7'h0, |exp_level(pins, pol, en)}, "R9 irq_any level");
        end
        wr(8'h94, 8'hFF); wr(8'h9C, 8'hFF);
        pins = 8'hFF; step(3);
        wr(8'h98, 8'hFF); step(1);
        chk(irq_line, 8'hFF, "R5 ack ignored in level mode");

        // R8 debounce on line 3, level-high
        clear_cfg();
        pins = 8'h00; step(60);
        wr(8'hA8, 8'h08); wr(8'h94, 8'h08); wr(8'h9C, 8'h08);
        step(2); chk(irq_line, 8'h00, "R8 idle low");
        pins = 8'h08; step(12);
        chk(irq_line, 8'h00, "R8 during short pulse");
        pins = 8'h00; step(40);
        chk(irq_line, 8'h00, "R8 short pulse discarded");
        pins = 8'h08; step(16);
        chk(irq_line, 8'h00, "R8 not before four ticks");
        step(44);
        chk(irq_line, 8'h08, "R8 accepted after four ticks");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule